// File: doc/BRIEF.md
# Packet Receiver with Acknowledge Decision

This block sits behind a line decoder and consumes its bit-parallel byte stream, one byte per clock when `rx_valid` is high. Once the carrier input shows that a transmission has begun, the block hunts for a pair of sync bytes. It then parses a short header: destination, source, type and a payload length. While it does this, it runs a CRC-32 over the header and payload. It collects the four trailing CRC bytes and compares them with its own result.

At the end of every complete packet the block issues a one-cycle response strobe carrying a request code. The code tells a response builder to send a positive acknowledge, a negative acknowledge (no room to store the packet), or nothing at all (a corrupted packet, a collision, or a packet meant for another node). A separate accept strobe, together with the parsed header fields, lets a buffer writer commit the packet. If the carrier drops part way through a packet, the packet is abandoned without any strobe.

Top module: `pkt_rx_ackdec`

## Requirements
- R1: After reset, and in every cycle without a strobe, `resp_valid` and `pkt_accept` are 0 and `resp_code` is 00.
- R2: Header parsing begins only after the carrier is high and two consecutive accepted bytes equal 0x96. A non-0x96 byte restarts the sync hunt. Bytes seen while the carrier is low are ignored.
- R3: The CRC has polynomial 0x04C11DB7, initial value 0xFFFFFFFF and a final inversion, and it is processed least significant bit first. It covers every byte from the destination byte through the last payload byte. The four CRC bytes follow, lowest-order byte first.
- R4: A packet that has a good CRC, is addressed to `my_addr` and sees buffer space gives `resp_code` 01 (ACK) with `pkt_accept` high. Both appear one cycle after the last CRC byte is accepted.
- R5: A packet that has a good CRC and is addressed to `my_addr` but has no buffer space gives `resp_code` 10 (NACK), with `pkt_accept` low.
- R6: A CRC mismatch gives a strobe with `resp_code` 00 and `pkt_accept` low. The code 11 is never issued.
- R7: When the destination byte differs from `my_addr`, the strobe carries `resp_code` 00 and `pkt_accept` stays low.
- R8: `buf_free` is sampled in the cycle that accepts the destination byte. Changes to it later in the packet have no effect on the decision.
- R9: A carrier loss before the last CRC byte aborts the packet, and no strobe follows. The next packet is received normally.
- R10: During the strobe, `hdr_src`, `hdr_type` and `hdr_len` show the second and third header bytes and the 16-bit length. The length is sent low byte first. A length of 0 goes straight to the CRC bytes.
- R11: `resp_valid` is high for exactly one cycle per completed packet.
- R12: Cycles with `rx_valid` low are skipped at any point in the packet without changing the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| carrier | input | 1 | Line activity from the decoder |
| rx_valid | input | 1 | `rx_byte` holds a new byte this cycle |
| rx_byte | input | 8 | Decoded byte |
| my_addr | input | 8 | This node's address |
| buf_free | input | 1 | Local receive buffer has room |
| resp_valid | output | 1 | One-cycle decision strobe |
| resp_code | output | 2 | 00 none, 01 ACK, 10 NACK |
| pkt_accept | output | 1 | Packet is good and stored (ACK case) |
| hdr_src | output | 8 | Source address of the packet |
| hdr_type | output | 8 | Type byte of the packet |
| hdr_len | output | 16 | Payload length |

## Verification
Every decision output is registered once after the final CRC byte is accepted. The bench therefore expects the strobe, the code, the accept flag and the header fields in the cycle that follows that byte, and sampling happens at the falling edge of that cycle. A reference model in the bench predicts the whole output set for every cycle and compares the actual outputs each cycle, so a strobe that comes early, comes late or repeats is caught. A carrier drop takes effect at the next edge, so the model expects silence from the drop onward.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;

    localparam int          BYTE_W        = 8;
    localparam int          CRC_W         = 32;
    localparam int          LEN_W         = 16;
    localparam int          CRC_BYTES     = CRC_W / BYTE_W;
    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED      = 32'hFFFFFFFF;

    typedef enum logic [1:0] {
        RESP_NONE = 2'b00,
        RESP_ACK  = 2'b01,
        RESP_NACK = 2'b10
    } resp_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SYNC,
        ST_DST,
        ST_SRC,
        ST_TYPE,
        ST_LENL,
        ST_LENH,
        ST_PAY,
        ST_CRC
    } rx_state_e;

    // One byte through a reflected CRC register, least significant bit first.
    function automatic logic [CRC_W-1:0] crc_byte(input logic [CRC_W-1:0] c,
                                                  input logic [BYTE_W-1:0] d,
                                                  input logic [CRC_W-1:0] poly);
        logic [CRC_W-1:0] r;
        logic             fb;
        r = c;
        for (int i = 0; i < BYTE_W; i++) begin
            fb = r[0] ^ d[i];
            r  = r >> 1;
            if (fb) r = r ^ poly;
        end
        return r;
    endfunction

endpackage

// File: rtl/pkt_rx_crc32.sv
module pkt_rx_crc32
    import pkt_rx_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY = CRC_POLY_REFL,
    parameter logic [CRC_W-1:0] SEED = CRC_SEED
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic [BYTE_W-1:0] data,
    output logic [CRC_W-1:0]  crc
);

    logic [CRC_W-1:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (clr)     crc_d = SEED;
        else if (en) crc_d = crc_byte(crc_q, data, POLY);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) crc_q <= SEED;
        else        crc_q <= crc_d;
    end

    assign crc = crc_q;

    // R3: the running value only moves on a clear or a byte
    p_crc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !en) |=> $stable(crc_q));

endmodule

// File: rtl/pkt_rx_sequencer.sv
module pkt_rx_sequencer
    import pkt_rx_pkg::*;
#(
    parameter logic [BYTE_W-1:0] SYNC_BYTE  = 8'h96,
    parameter int                SYNC_COUNT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              carrier,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              buf_free,
    output logic              crc_clr,
    output logic              crc_en,
    output logic              end_pulse,
    output logic [BYTE_W-1:0] dst,
    output logic [BYTE_W-1:0] src,
    output logic [BYTE_W-1:0] typ,
    output logic [LEN_W-1:0]  len,
    output logic              space,
    output logic [CRC_W-1:0]  rx_crc
);

    localparam int SC_W = $clog2(SYNC_COUNT + 1);
    localparam int BC_W = $clog2(CRC_BYTES);

    typedef struct packed {
        rx_state_e         st;
        logic [SC_W-1:0]   sync_cnt;
        logic [BYTE_W-1:0] dst;
        logic [BYTE_W-1:0] src;
        logic [BYTE_W-1:0] typ;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  cnt;
        logic              space;
        logic [CRC_W-1:0]  rcrc;
    } seq_t;

    seq_t seq_d, seq_q;
    logic take;

    assign take = rx_valid && carrier;

    always_comb begin
        seq_d     = seq_q;
        crc_clr   = 1'b0;
        crc_en    = 1'b0;
        end_pulse = 1'b0;
        if (!carrier && seq_q.st != ST_IDLE) begin
            seq_d.st       = ST_IDLE;
            seq_d.sync_cnt = '0;
        end else begin
            case (seq_q.st)
                ST_IDLE: begin
                    if (carrier) begin
                        seq_d.st       = ST_SYNC;
                        seq_d.sync_cnt = '0;
                    end
                end
                ST_SYNC: begin
                    if (take) begin
                        if (rx_byte == SYNC_BYTE) begin
                            if (seq_q.sync_cnt == SC_W'(SYNC_COUNT - 1)) begin
                                seq_d.st       = ST_DST;
                                seq_d.sync_cnt = '0;
                                crc_clr        = 1'b1;
                            end else begin
                                seq_d.sync_cnt = seq_q.sync_cnt + 1'b1;
                            end
                        end else begin
                            seq_d.sync_cnt = '0;
                        end
                    end
                end
                ST_DST: begin
                    if (take) begin
                        seq_d.dst   = rx_byte;
                        seq_d.space = buf_free;
                        seq_d.st    = ST_SRC;
                        crc_en      = 1'b1;
                    end
                end
                ST_SRC: begin
                    if (take) begin
                        seq_d.src = rx_byte;
                        seq_d.st  = ST_TYPE;
                        crc_en    = 1'b1;
                    end
                end
                ST_TYPE: begin
                    if (take) begin
                        seq_d.typ = rx_byte;
                        seq_d.st  = ST_LENL;
                        crc_en    = 1'b1;
                    end
                end
                ST_LENL: begin
                    if (take) begin
                        seq_d.len[BYTE_W-1:0] = rx_byte;
                        seq_d.st              = ST_LENH;
                        crc_en                = 1'b1;
                    end
                end
                ST_LENH: begin
                    if (take) begin
                        seq_d.len[LEN_W-1:BYTE_W] = rx_byte;
                        crc_en                    = 1'b1;
                        if ({rx_byte, seq_q.len[BYTE_W-1:0]} == '0) begin
                            seq_d.st  = ST_CRC;
                            seq_d.cnt = '0;
                        end else begin
                            seq_d.st  = ST_PAY;
                            seq_d.cnt = {rx_byte, seq_q.len[BYTE_W-1:0]};
                        end
                    end
                end
                ST_PAY: begin
                    if (take) begin
                        crc_en = 1'b1;
                        if (seq_q.cnt == LEN_W'(1)) begin
                            seq_d.st  = ST_CRC;
                            seq_d.cnt = '0;
                        end else begin
                            seq_d.cnt = seq_q.cnt - 1'b1;
                        end
                    end
                end
                ST_CRC: begin
                    if (take) begin
                        seq_d.rcrc = {rx_byte, seq_q.rcrc[CRC_W-1:BYTE_W]};
                        if (seq_q.cnt[BC_W-1:0] == BC_W'(CRC_BYTES - 1)) begin
                            end_pulse = 1'b1;
                            seq_d.st  = ST_IDLE;
                            seq_d.cnt = '0;
                        end else begin
                            seq_d.cnt = seq_q.cnt + 1'b1;
                        end
                    end
                end
                default: seq_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q    <= '0;
            seq_q.st <= ST_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign dst    = seq_q.dst;
    assign src    = seq_q.src;
    assign typ    = seq_q.typ;
    assign len    = seq_q.len;
    assign space  = seq_q.space;
    assign rx_crc = {rx_byte, seq_q.rcrc[CRC_W-1:BYTE_W]};

    // R2: the header is only entered from the sync hunt
    p_hdr_after_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_DST) |-> ($past(seq_q.st) == ST_SYNC || $past(seq_q.st) == ST_DST));

    // R9: without carrier nothing completes
    p_no_end_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !carrier |-> !end_pulse);

endmodule

// File: rtl/pkt_rx_ackdec.sv
module pkt_rx_ackdec
    import pkt_rx_pkg::*;
#(
    parameter logic [7:0] SYNC_BYTE  = 8'h96,
    parameter int         SYNC_COUNT = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        carrier,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    input  logic [7:0]  my_addr,
    input  logic        buf_free,
    output logic        resp_valid,
    output logic [1:0]  resp_code,
    output logic        pkt_accept,
    output logic [7:0]  hdr_src,
    output logic [7:0]  hdr_type,
    output logic [15:0] hdr_len
);

    typedef struct packed {
        logic              valid;
        resp_e             code;
        logic              accept;
        logic [BYTE_W-1:0] src;
        logic [BYTE_W-1:0] typ;
        logic [LEN_W-1:0]  len;
    } dec_t;

    logic              crc_clr, crc_en, end_pulse, space;
    logic [BYTE_W-1:0] dst, src, typ;
    logic [LEN_W-1:0]  len;
    logic [CRC_W-1:0]  rx_crc, crc_run;
    logic              crc_good, addr_hit;
    dec_t              dec_d, dec_q;

    pkt_rx_sequencer #(
        .SYNC_BYTE  (SYNC_BYTE),
        .SYNC_COUNT (SYNC_COUNT)
    ) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .carrier   (carrier),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .buf_free  (buf_free),
        .crc_clr   (crc_clr),
        .crc_en    (crc_en),
        .end_pulse (end_pulse),
        .dst       (dst),
        .src       (src),
        .typ       (typ),
        .len       (len),
        .space     (space),
        .rx_crc    (rx_crc)
    );

    pkt_rx_crc32 i_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (crc_clr),
        .en    (crc_en),
        .data  (rx_byte),
        .crc   (crc_run)
    );

    assign crc_good = (rx_crc == ~crc_run);
    assign addr_hit = (dst == my_addr);

    always_comb begin
        dec_d = '0;
        if (end_pulse) begin
            dec_d.valid = 1'b1;
            dec_d.src   = src;
            dec_d.typ   = typ;
            dec_d.len   = len;
            if (!crc_good || !addr_hit) begin
                dec_d.code = RESP_NONE;
            end else if (space) begin
                dec_d.code   = RESP_ACK;
                dec_d.accept = 1'b1;
            end else begin
                dec_d.code = RESP_NACK;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    assign resp_valid = dec_q.valid;
    assign resp_code  = dec_q.code;
    assign pkt_accept = dec_q.accept;
    assign hdr_src    = dec_q.src;
    assign hdr_type   = dec_q.typ;
    assign hdr_len    = dec_q.len;

    p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_valid |-> (resp_code == RESP_NONE && !pkt_accept));

    p_accept_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_accept |-> (resp_valid && resp_code == RESP_ACK));

    p_legal_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_code != 2'b11));

    p_drop_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !carrier |=> !resp_valid);

    p_one_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

endmodule

// File: tb/test_pkt_rx_ackdec.sv
module test_pkt_rx_ackdec;

    localparam logic [7:0] MY = 8'h42;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        carrier = 1'b0, rx_valid = 1'b0, buf_free = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        resp_valid, pkt_accept;
    logic [1:0]  resp_code;
    logic [7:0]  hdr_src, hdr_type;
    logic [15:0] hdr_len;

    int    checks = 0, errors = 0;
    bit    finished = 1'b0;
    string cur_req = "R1";

    // expected outputs for the next sampled cycle
    bit          exp_v = 1'b0;
    logic [1:0]  exp_code = 2'b00;
    logic [7:0]  exp_src, exp_typ;
    logic [15:0] exp_len;

    logic [7:0] body[$];
    logic [7:0] frame[$];

    always #10 clk = ~clk;

    pkt_rx_ackdec i_pkt_rx_ackdec (
        .clk(clk), .rst_n(rst_n), .carrier(carrier), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .my_addr(MY), .buf_free(buf_free),
        .resp_valid(resp_valid), .resp_code(resp_code), .pkt_accept(pkt_accept),
        .hdr_src(hdr_src), .hdr_type(hdr_type), .hdr_len(hdr_len)
    );

    // Non-reflected formulation on bit-reversed bytes
    function automatic logic [31:0] ref_crc();
        logic [31:0] r, o;
        logic [7:0]  rb;
        r = 32'hFFFFFFFF;
        foreach (body[k]) begin
            for (int b = 0; b < 8; b++) rb[b] = body[k][7-b];
            r = r ^ {rb, 24'h0};
            for (int b = 0; b < 8; b++) r = r[31] ? ((r << 1) ^ 32'h04C11DB7) : (r << 1);
        end
        for (int b = 0; b < 32; b++) o[b] = r[31-b];
        return ~o;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // one clock: compare the cycle just ended, then drive the next one
    task automatic tick(input bit v, input logic [7:0] d, input bit car, input bit bf);
        string tag;
        @(negedge clk);
        tag = exp_v ? cur_req : $sformatf("R11 %s", cur_req);
        check(resp_valid == exp_v, tag, "resp_valid", 32'(resp_valid), 32'(exp_v));
        check(resp_code == (exp_v ? exp_code : 2'b00), tag, "resp_code",
              32'(resp_code), 32'(exp_v ? exp_code : 2'b00));
        check(pkt_accept == (exp_v && exp_code == 2'b01), tag, "pkt_accept",
              32'(pkt_accept), 32'(exp_v && exp_code == 2'b01));
        if (exp_v) begin
            check(hdr_src == exp_src, "R10", "hdr_src", 32'(hdr_src), 32'(exp_src));
            check(hdr_type == exp_typ, "R10", "hdr_type", 32'(hdr_type), 32'(exp_typ));
            check(hdr_len == exp_len, "R10", "hdr_len", 32'(hdr_len), 32'(exp_len));
        end
        exp_v    = 1'b0;
        carrier  = car;
        rx_valid = v;
        rx_byte  = d;
        buf_free = bf;
    endtask

    task automatic send_pkt(input logic [7:0] dst, input logic [7:0] src, input logic [7:0] typ,
                            input int n, input logic [7:0] seed, input bit bad,
                            input bit bf_dst, input bit bf_after, input int drop_at,
                            input int gap, input string req);
        logic [31:0] c;
        logic [1:0]  code;
        cur_req = req;
        body.delete();
        frame.delete();
        body.push_back(dst); body.push_back(src); body.push_back(typ);
        body.push_back(8'(n)); body.push_back(8'(n >> 8));
        for (int i = 0; i < n; i++) body.push_back(seed + 8'(i));
        c = ref_crc();
        if (bad) c[0] = ~c[0];
        frame.push_back(8'h96); frame.push_back(8'h96);
        foreach (body[k]) frame.push_back(body[k]);
        for (int i = 0; i < 4; i++) frame.push_back(c[8*i +: 8]);
        code = (bad || dst != MY) ? 2'b00 : (bf_dst ? 2'b01 : 2'b10);
        tick(1'b0, 8'h00, 1'b1, bf_after);
        for (int i = 0; i < frame.size(); i++) begin
            if (i == drop_at) begin
                tick(1'b0, 8'h00, 1'b0, bf_after);
                break;
            end
            tick(1'b1, frame[i], 1'b1, (i == 2) ? bf_dst : bf_after);
            if (i == frame.size() - 1) begin
                exp_v = 1'b1; exp_code = code;
                exp_src = src; exp_typ = typ; exp_len = 16'(n);
            end else if (gap != 0 && (i % gap) == gap - 1) begin
                tick(1'b0, 8'hA5, 1'b1, bf_after);
            end
        end
        tick(1'b0, 8'h00, 1'b0, 1'b0);
        tick(1'b0, 8'h00, 1'b0, 1'b0);
        tick(1'b0, 8'h00, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, also compared every idle cycle below
        cur_req = "R1";
        repeat (3) tick(1'b0, 8'h00, 1'b0, 1'b0);

        // R3: reference CRC self test on the standard check string
        body.delete();
        for (int i = 0; i < 9; i++) body.push_back(8'h31 + 8'(i));
        check(ref_crc() == 32'hCBF43926, "R3", "bench crc", ref_crc(), 32'hCBF43926);

        send_pkt(MY, 8'h11, 8'h05, 4, 8'h10, 0, 1, 1, -1, 0, "R4");
        send_pkt(MY, 8'h12, 8'h06, 7, 8'h20, 0, 0, 0, -1, 0, "R5");
        send_pkt(MY, 8'h13, 8'h07, 5, 8'h30, 1, 1, 1, -1, 0, "R6");
        send_pkt(8'h43, 8'h14, 8'h08, 3, 8'h40, 0, 1, 1, -1, 0, "R7");
        send_pkt(MY, 8'h15, 8'h09, 6, 8'h50, 0, 1, 0, -1, 0, "R8");
        send_pkt(MY, 8'h16, 8'h0A, 6, 8'h58, 0, 0, 1, -1, 0, "R8");
        send_pkt(MY, 8'h17, 8'h0B, 0, 8'h00, 0, 1, 1, -1, 0, "R10");
        send_pkt(MY, 8'h18, 8'h0C, 300, 8'h00, 0, 1, 1, -1, 0, "R3");
        send_pkt(MY, 8'h19, 8'h0D, 9, 8'h60, 0, 1, 1, -1, 2, "R12");
        send_pkt(MY, 8'h1A, 8'h0E, 9, 8'h61, 0, 0, 0, -1, 3, "R12");
        send_pkt(MY, 8'h1B, 8'h0F, 10, 8'h70, 0, 1, 1, 9, 0, "R9");
        send_pkt(MY, 8'h1C, 8'h10, 10, 8'h70, 0, 1, 1, 16, 0, "R9");
        send_pkt(MY, 8'h1D, 8'h11, 2, 8'h71, 0, 1, 1, -1, 0, "R9");

        // R2: bytes without carrier, then a single sync followed by junk
        cur_req = "R2";
        tick(1'b1, 8'h96, 1'b0, 1'b1);
        tick(1'b1, 8'h96, 1'b0, 1'b1);
        tick(1'b1, 8'h00, 1'b0, 1'b1);
        body.delete();
        body.push_back(MY); body.push_back(8'h20); body.push_back(8'h01);
        body.push_back(8'h00); body.push_back(8'h00);
        tick(1'b0, 8'h00, 1'b1, 1'b1);
        tick(1'b1, 8'h96, 1'b1, 1'b1);
        tick(1'b1, 8'h33, 1'b1, 1'b1);
        foreach (body[k]) tick(1'b1, body[k], 1'b1, 1'b1);
        for (int i = 0; i < 4; i++) tick(1'b1, ref_crc() >> (8*i), 1'b1, 1'b1);
        repeat (3) tick(1'b0, 8'h00, 1'b0, 1'b0);
        // R2: junk and a broken sync before a proper one still give ACK
        cur_req = "R2";
        tick(1'b0, 8'h00, 1'b1, 1'b1);
        tick(1'b1, 8'h00, 1'b1, 1'b1);
        tick(1'b1, 8'h96, 1'b1, 1'b1);
        tick(1'b1, 8'h33, 1'b1, 1'b1);
        tick(1'b1, 8'h96, 1'b1, 1'b1);
        tick(1'b1, 8'h96, 1'b1, 1'b1);
        foreach (body[k]) tick(1'b1, body[k], 1'b1, 1'b1);
        for (int i = 0; i < 4; i++) begin
            tick(1'b1, ref_crc() >> (8*i), 1'b1, 1'b1);
            if (i == 3) begin
                exp_v = 1'b1; exp_code = 2'b01;
                exp_src = 8'h20; exp_typ = 8'h01; exp_len = 16'h0000;
            end
        end
        repeat (3) tick(1'b0, 8'h00, 1'b0, 1'b0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired in %s", cur_req);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule